// File: doc/BRIEF.md
# Up/down wiper position controller

This block is the digital control for a 32-position resistor tap selector. It is driven by a two-wire interface: an active-low select line and an up/down line. Both lines are asynchronous to the block. They are resynchronized onto the system clock, and all decisions are taken from edges of the synchronized copies.

When select falls, the block takes the step direction from the up/down level. Up/down high means count up and up/down low means count down. The direction then stays fixed for the whole session. While select stays low, each rising edge on up/down moves the tap by one position in that direction. The count stops at position 0 and at position 31 and does not wrap. When select returns high, the position is held until a later session changes it.

The block drives a registered 5-bit tap code, a one-hot select with one line per tap, and a one-clock strobe for every real change of position. Reset loads midscale, which is position 16.

Top module: `tap_step_ctrl`

## Requirements
- R1: After reset `tap_code` is 16 (binary 10000), `tap_onehot` has only bit 16 set, and `step_pulse` is low.
- R2: When `sel_n` falls while `updn` is high, the session counts up. Each later rising edge of `updn` while `sel_n` stays low adds one to `tap_code`.
- R3: When `sel_n` falls while `updn` is low, the session counts down. Each later rising edge of `updn` while `sel_n` stays low subtracts one from `tap_code`.
- R4: The direction latched at the fall of `sel_n` stays fixed until `sel_n` goes high, whatever levels `updn` takes in between.
- R5: While `sel_n` is high, edges on `updn` have no effect: `tap_code` holds and `step_pulse` stays low.
- R6: A count-up step at 31 leaves `tap_code` at 31, and a count-down step at 0 leaves it at 0. There is no wraparound, and no `step_pulse` is produced in either case.
- R7: If the synchronized `sel_n` falls in the same clock as the synchronized `updn` rises, the direction is taken from the `updn` level before that edge (low, so count down) and no step is made in that clock.
- R8: `tap_onehot` always has exactly one bit set, the bit whose index is `tap_code`.
- R9: `step_pulse` is high for exactly one clock for each change of `tap_code`. After an `updn` edge is applied between clock edges, `tap_code` and `step_pulse` change at the third rising clock edge that follows.
- R10: The position reached in a session is kept after `sel_n` returns high. A later session continues from that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; loads midscale |
| sel_n | input | 1 | Active-low interface select, asynchronous |
| updn | input | 1 | Direction level at the fall of select, then the step clock; asynchronous |
| tap_code | output | 5 | Registered tap position, 0 to 31 |
| tap_onehot | output | 32 | One-hot tap select decoded from tap_code |
| step_pulse | output | 1 | One-clock strobe when the position changes |

## Verification
A wrong direction latch shows up on the first step of a session: three clocks after the `updn` edge, the tap code moves the wrong way. A stale or lost edge detector shows up within the same three clocks, either as a missing strobe or as a second strobe for one edge. Saturation faults become visible only once the position reaches an end and one more step is requested. For that reason the directed tests drive the position fully to both ends. A decoder fault is visible at once on `tap_onehot` for whatever code is currently held.

// File: rtl/updn_pkg.sv
package updn_pkg;

  localparam int unsigned TAPS_DEFAULT = 32;
  localparam int unsigned SYNC_DEFAULT = 2;

  typedef enum logic {
    MODE_DN = 1'b0,
    MODE_UP = 1'b1
  } mode_e;

  // Next position for one step in the given direction, clamped to 0..last.
  function automatic int unsigned sat_next(input int unsigned pos,
                                           input logic up,
                                           input int unsigned last);
    int unsigned r;
    if (up) r = (pos >= last) ? last : pos + 1;
    else    r = (pos == 0) ? 0 : pos - 1;
    return r;
  endfunction

  // Reset position: the middle tap.
  function automatic int unsigned mid_tap(input int unsigned taps);
    return taps / 2;
  endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/updn_edge_ctrl.sv
module updn_edge_ctrl
  import updn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_s,
  input  logic  ud_s,
  output logic  sel_active,
  output logic  sel_fall,
  output logic  ud_rise,
  output logic  step_req,
  output mode_e mode
);
  logic sel_d;
  logic ud_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d <= 1'b1;
      ud_d  <= 1'b0;
    end else begin
      sel_d <= sel_s;
      ud_d  <= ud_s;
    end
  end

  assign sel_fall   = sel_d & ~sel_s;
  assign ud_rise    = ~ud_d & ud_s;
  assign sel_active = ~sel_s;
  // A step needs a session that was already open in the previous clock.
  assign step_req   = ~sel_s & ~sel_d & ud_rise;

  // The direction comes from the level before the edge, so a rise of up/down
  // in the same clock as the select fall does not set count-up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode <= MODE_UP;
    else if (sel_fall) mode <= ud_d ? MODE_UP : MODE_DN;
  end
endmodule

// File: rtl/updn_pos_reg.sv
module updn_pos_reg
  import updn_pkg::*;
#(
  parameter int unsigned TAPS  = TAPS_DEFAULT,
  localparam int unsigned TAP_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  mode_e            mode,
  output logic [TAP_W-1:0] pos,
  output logic             step_pulse
);
  localparam int unsigned LAST = TAPS - 1;
  localparam logic [TAP_W-1:0] MID = TAP_W'(mid_tap(TAPS));

  logic [TAP_W-1:0] next_pos;
  logic             moves;

  assign next_pos = TAP_W'(sat_next(32'(pos), mode == MODE_UP, LAST));
  assign moves    = step_req && (next_pos != pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= MID;
      step_pulse <= 1'b0;
    end else begin
      step_pulse <= moves;
      if (moves) pos <= next_pos;
    end
  end
endmodule

// File: rtl/updn_tap_decode.sv
module updn_tap_decode #(
  parameter int unsigned TAPS  = 32,
  localparam int unsigned TAP_W = $clog2(TAPS)
) (
  input  logic [TAP_W-1:0] code,
  output logic [TAPS-1:0]  onehot
);
  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_line
      assign onehot[i] = (code == TAP_W'(i));
    end
  endgenerate
endmodule

// File: rtl/tap_step_ctrl.sv
module tap_step_ctrl
  import updn_pkg::*;
#(
  parameter int unsigned TAPS   = TAPS_DEFAULT,
  parameter int unsigned STAGES = SYNC_DEFAULT,
  localparam int unsigned TAP_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             updn,
  output logic [TAP_W-1:0] tap_code,
  output logic [TAPS-1:0]  tap_onehot,
  output logic             step_pulse
);
  logic  sel_s;
  logic  ud_s;
  logic  sel_active;
  logic  sel_fall;
  logic  ud_rise;
  logic  step_req;
  mode_e mode;
  logic  mode_up;

  updn_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_s)
  );

  updn_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync_ud (
    .clk(clk), .rst_n(rst_n), .d(updn), .q(ud_s)
  );

  updn_edge_ctrl u_edge (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .ud_s(ud_s),
    .sel_active(sel_active), .sel_fall(sel_fall), .ud_rise(ud_rise),
    .step_req(step_req), .mode(mode)
  );

  assign mode_up = (mode == MODE_UP);

  updn_pos_reg #(.TAPS(TAPS)) u_pos (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .mode(mode),
    .pos(tap_code), .step_pulse(step_pulse)
  );

  updn_tap_decode #(.TAPS(TAPS)) u_dec (
    .code(tap_code), .onehot(tap_onehot)
  );
endmodule

// File: rtl/tap_step_ctrl_chk.sv
module tap_step_ctrl_chk #(
  parameter int unsigned TAPS  = 32,
  localparam int unsigned TAP_W = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAP_W-1:0] tap_code,
  input logic [TAPS-1:0]  tap_onehot,
  input logic             step_pulse,
  input logic             sel_active,
  input logic             sel_fall,
  input logic             step_req,
  input logic             mode_up
);
  localparam logic [TAP_W-1:0] LAST = TAP_W'(TAPS - 1);

  // R8
  onehot_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_onehot) == 1) && tap_onehot[tap_code]);

  // R9
  pulse_means_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> (tap_code != $past(tap_code)));

  // R9
  quiet_means_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pulse |-> $stable(tap_code));

  // R5
  idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> !step_pulse);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tap_code == LAST) |=> (tap_code != '0)) and
    ((tap_code == '0) |=> (tap_code != LAST)));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_fall |=> $stable(mode_up));

  // R2
  up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && mode_up && tap_code != LAST) |=> (tap_code == $past(tap_code) + 1'b1));

  // R3
  dn_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !mode_up && tap_code != '0) |=> (tap_code == $past(tap_code) - 1'b1));
endmodule

bind tap_step_ctrl tap_step_ctrl_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tap_code(tap_code), .tap_onehot(tap_onehot),
  .step_pulse(step_pulse), .sel_active(sel_active), .sel_fall(sel_fall),
  .step_req(step_req), .mode_up(mode_up)
);

// File: tb/tap_step_ctrl_bench.sv
`timescale 1ns/1ps
module tap_step_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        updn = 1'b0;
  logic [4:0]  tap_code;
  logic [31:0] tap_onehot;
  logic        step_pulse;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  int expp = 16;
  bit done = 0;

  always #2.5 clk = ~clk;

  tap_step_ctrl u_tap_step_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .updn(updn),
    .tap_code(tap_code), .tap_onehot(tap_onehot), .step_pulse(step_pulse)
  );

  always @(negedge clk) if (rst_n && step_pulse) pulses++;

  task automatic check(input string req, input int act, input int exp_v);
    tests++;
    if (act != exp_v) begin
      fails++;
      $display("[TB] FAIL %s act=%0d exp=%0d", req, act, exp_v);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int model_step(input int p, input bit up);
    if (up) return (p == 31) ? 31 : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  task automatic open_session(input bit lvl);
    @(negedge clk); updn = lvl; idle(4);
    sel_n = 1'b0; idle(4);
  endtask

  task automatic close_session();
    @(negedge clk); sel_n = 1'b1; idle(4);
  endtask

  task automatic pulse_ud();
    @(negedge clk); updn = 1'b0; idle(3);
    updn = 1'b1; idle(4);
  endtask

  task automatic t_reset();
    check("R1 code", int'(tap_code), 16);
    check("R1 onehot", int'(tap_onehot == 32'h0001_0000), 1);
    check("R1 pulse", int'(step_pulse), 0);
  endtask

  task automatic t_up();
    open_session(1'b1);
    for (int i = 0; i < 3; i++) begin
      pulse_ud(); expp = model_step(expp, 1'b1);
      check("R2 up step", int'(tap_code), expp);
      check("R8 onehot", int'(tap_onehot == (32'd1 << expp)), 1);
    end
    close_session();
  endtask

  task automatic t_latency();
    int p0;
    open_session(1'b0);
    @(negedge clk); updn = 1'b0; idle(4);
    p0 = pulses;
    updn = 1'b1;
    @(negedge clk);
    check("R9 no change edge1", int'(tap_code), expp);
    @(negedge clk);
    check("R9 no change edge2", int'(tap_code), expp);
    @(negedge clk);
    expp = model_step(expp, 1'b0);
    check("R9 change edge3", int'(tap_code), expp);
    check("R9 pulse high", int'(step_pulse), 1);
    @(negedge clk);
    check("R9 pulse one clock", int'(step_pulse), 0);
    idle(3);
    check("R9 pulse count", pulses - p0, 1);
    close_session();
  endtask

  task automatic t_down_and_mode();
    open_session(1'b0);
    for (int i = 0; i < 2; i++) begin
      pulse_ud(); expp = model_step(expp, 1'b0);
      check("R3 down step", int'(tap_code), expp);
    end
    // updn left high for a while, then stepped again: still counts down
    idle(6);
    pulse_ud(); expp = model_step(expp, 1'b0);
    check("R4 mode fixed", int'(tap_code), expp);
    close_session();
    check("R10 held after close", int'(tap_code), expp);
  endtask

  task automatic t_idle_ignored();
    int p0 = pulses;
    for (int i = 0; i < 4; i++) pulse_ud();
    check("R5 code held", int'(tap_code), expp);
    check("R5 no pulse", pulses - p0, 0);
  endtask

  task automatic t_sat_top();
    int p0;
    open_session(1'b1);
    while (expp < 31) begin pulse_ud(); expp = model_step(expp, 1'b1); end
    check("R2 reached top", int'(tap_code), 31);
    p0 = pulses;
    pulse_ud(); pulse_ud();
    check("R6 top clamp", int'(tap_code), 31);
    check("R6 top no pulse", pulses - p0, 0);
    check("R8 top line", int'(tap_onehot == 32'h8000_0000), 1);
    close_session();
  endtask

  task automatic t_sat_bottom();
    int p0;
    open_session(1'b0);
    while (expp > 0) begin pulse_ud(); expp = model_step(expp, 1'b0); end
    check("R3 reached bottom", int'(tap_code), 0);
    p0 = pulses;
    pulse_ud(); pulse_ud();
    check("R6 bottom clamp", int'(tap_code), 0);
    check("R6 bottom no pulse", pulses - p0, 0);
    close_session();
  endtask

  task automatic t_same_cycle();
    int p0;
    // move up first so a down step is visible
    open_session(1'b1);
    pulse_ud(); pulse_ud();
    expp = model_step(model_step(expp, 1'b1), 1'b1);
    close_session();
    @(negedge clk); updn = 1'b0; idle(4);
    p0 = pulses;
    sel_n = 1'b0; updn = 1'b1;
    idle(6);
    check("R7 no step on coincident edges", int'(tap_code), expp);
    check("R7 no pulse", pulses - p0, 0);
    pulse_ud(); expp = model_step(expp, 1'b0);
    check("R7 direction from old level", int'(tap_code), expp);
    close_session();
  endtask

  task automatic t_resume();
    open_session(1'b1);
    pulse_ud(); expp = model_step(expp, 1'b1);
    check("R10 resumes from stored", int'(tap_code), expp);
    close_session();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("[TB] FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1; idle(4);
    t_reset();
    t_up();
    t_latency();
    t_down_and_mode();
    t_idle_ignored();
    t_sat_top();
    t_sat_bottom();
    t_same_cycle();
    t_resume();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule